// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This block watches the instruction address bus of an 8-bit CPU and raises a breakpoint when the bus equals a programmed break address. The break address is split into byte lanes. Each lane has its own byte-wide register and its own byte comparator. A hit counts only when every lane agrees and the unit is armed.

A hit never interrupts an instruction partway through. If the hit lands on the final cycle of an instruction, the break is issued right after that cycle. If it lands earlier, a single pending bit holds it until the end-of-instruction strobe arrives. The break itself is a one-cycle pulse. During that pulse the unit drives the software-interrupt opcode for the core to load into its instruction register. It also drives the vector address the core fetches next, and that address moves to a separate page while the monitor-mode input is high.

Software uses a byte-wide register bus to program the address, arm the unit and read the sticky flags. Each flag is cleared by writing a zero to its bit.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, offset 0x00 reads 0x10, and offsets 0x03, 0x09, 0x0A and 0x0B read 0x00. No break pulse is issued.
- R2: Offset 0x09 holds the upper address byte and offset 0x0A holds the lower byte, and both read back what was written. Offsets outside 0x00, 0x03, 0x09, 0x0A and 0x0B read 0x00, and writes to them change no register.
- R3: A hit needs both address bytes equal and the arm bit (bit 7 of offset 0x0B) set. Each hit sets the active flag (bit 6 of offset 0x0B), visible from the next cycle. While the arm bit is 0, a matching address sets nothing.
- R4: The active flag stays set until a write to offset 0x0B carries 0 in bit 6. Writing 1 there leaves the flag unchanged. A hit in the same cycle as the clearing write leaves the flag set.
- R5: A hit in a cycle where `instr_last` is high produces `brk_take` high in the following cycle.
- R6: A hit while `instr_last` is low is held pending. It produces `brk_take` one cycle after the next cycle with `instr_last` high. Clearing the arm bit discards a pending break.
- R7: While `brk_take` is high, `swi_opcode` is 0x83 and `vec_addr` is 0xFFFC, or 0xFEFC if `monitor_mode` was high in the previous cycle. While `brk_take` is low, both are zero.
- R8: Bit 1 of offset 0x00 is set when a break is issued while `cpu_in_wait` is high. Writing 0 to that bit clears it and writing 1 has no effect. Bit 4 of offset 0x00 always reads 1.
- R9: Bit 7 of offset 0x03 is a read/write control bit. The other bits of offset 0x03 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset, shared by reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cpu_addr | input | 16 | CPU instruction address bus |
| instr_last | input | 1 | High on the final cycle of each instruction |
| monitor_mode | input | 1 | Selects the monitor vector page |
| cpu_in_wait | input | 1 | CPU is in its low-power wait state |
| brk_take | output | 1 | One-cycle break pulse |
| brk_active | output | 1 | Sticky active flag |
| swi_opcode | output | 8 | Forced opcode during the pulse, else zero |
| vec_addr | output | 16 | Vector address during the pulse, else zero |

## Verification
The bench builds the block with its default parameters: a 16-bit address in two byte lanes, and vectors 0xFFFC and 0xFEFC. With these values every offset of the 4-bit register space can be read. A random address lands on the programmed one often enough that hits fall both on and off instruction boundaries, and back-to-back breaks occur when hits repeat. Comparing against partly matching addresses, where only one byte agrees, shows that each lane is decided independently.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    localparam int REG_OFF_W  = 4;
    localparam int REG_DATA_W = 8;

    localparam int OFF_STATUS  = 0;
    localparam int OFF_FLAGCTL = 3;
    localparam int OFF_ADDR_HI = 9;
    localparam int OFF_CTL     = 11;

    localparam int BIT_ARM   = 7;
    localparam int BIT_ACT   = 6;
    localparam int BIT_WAIT  = 1;
    localparam int BIT_FIXED = 4;
    localparam int BIT_FCE   = 7;

    localparam logic [REG_DATA_W-1:0] SWI_OP = 8'h83;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_FLAGCTL,
        SEL_ADDR,
        SEL_CTL
    } reg_sel_e;

    typedef struct packed {
        logic                  we;
        logic [REG_OFF_W-1:0]  off;
        logic [REG_DATA_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic take;
        logic mon;
    } brk_evt_t;

    // The upper byte sits at the lowest offset, lower lanes follow
    function automatic int lane_offset(int lanes, int lane);
        return OFF_ADDR_HI + (lanes - 1 - lane);
    endfunction

    function automatic reg_sel_e decode_off(logic [REG_OFF_W-1:0] off, int lanes);
        if (int'(off) == OFF_STATUS)  return SEL_STATUS;
        if (int'(off) == OFF_FLAGCTL) return SEL_FLAGCTL;
        if (int'(off) == OFF_CTL)     return SEL_CTL;
        if (int'(off) >= OFF_ADDR_HI && int'(off) < OFF_ADDR_HI + lanes) return SEL_ADDR;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/brkpt_compare.sv
module brkpt_compare
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ADDR_W-1:0] brk_addr,
    output logic              addr_eq
);
    localparam int LANES = ADDR_W / REG_DATA_W;

    logic [LANES-1:0] lane_eq;

    // One byte comparator per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (cpu_addr[g*REG_DATA_W +: REG_DATA_W]
                          == brk_addr[g*REG_DATA_W +: REG_DATA_W]);
    end

    assign addr_eq = &lane_eq;
endmodule

// File: rtl/brkpt_regs.sv
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr,
    input  logic                  hit,
    input  logic                  take_now,
    input  logic                  cpu_in_wait,
    output logic [REG_DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0]     brk_addr,
    output logic                  brk_en,
    output logic                  brk_active
);
    localparam int LANES = ADDR_W / REG_DATA_W;

    reg_sel_e sel;
    logic     arm_q, act_q, wait_q, fce_q;

    assign sel = decode_off(wr.off, LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        localparam int LANE_OFF = lane_offset(LANES, g);
        logic [REG_DATA_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr.we && int'(wr.off) == LANE_OFF) begin
                byte_q <= wr.data;
            end
        end
        assign brk_addr[g*REG_DATA_W +: REG_DATA_W] = byte_q;
    end

    // Control: arm bit plus sticky active flag (a set beats a clear)
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            act_q <= 1'b0;
        end else begin
            if (wr.we && sel == SEL_CTL) begin
                arm_q <= wr.data[BIT_ARM];
                if (!wr.data[BIT_ACT]) act_q <= 1'b0;
            end
            if (hit) act_q <= 1'b1;
        end
    end

    // Status: wait-break flag, cleared only by a zero write
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= 1'b0;
        end else begin
            if (wr.we && sel == SEL_STATUS && !wr.data[BIT_WAIT]) wait_q <= 1'b0;
            if (take_now && cpu_in_wait) wait_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fce_q <= 1'b0;
        end else if (wr.we && sel == SEL_FLAGCTL) begin
            fce_q <= wr.data[BIT_FCE];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_STATUS: begin
                rdata[BIT_FIXED] = 1'b1;
                rdata[BIT_WAIT]  = wait_q;
            end
            SEL_FLAGCTL: rdata[BIT_FCE] = fce_q;
            SEL_ADDR: begin
                for (int i = 0; i < LANES; i++) begin
                    if (int'(wr.off) == lane_offset(LANES, i))
                        rdata = brk_addr[i*REG_DATA_W +: REG_DATA_W];
                end
            end
            SEL_CTL: begin
                rdata[BIT_ARM] = arm_q;
                rdata[BIT_ACT] = act_q;
            end
            default: rdata = '0;
        endcase
    end

    assign brk_en     = arm_q;
    assign brk_active = act_q;
endmodule

// File: rtl/brkpt_sequencer.sv
module brkpt_sequencer
    import brkpt_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NORM_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] MON_VEC  = 16'hFEFC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  brk_en,
    input  logic                  hit,
    input  logic                  instr_last,
    input  logic                  monitor_mode,
    output logic                  take_now,
    output logic                  brk_take,
    output logic [REG_DATA_W-1:0] swi_opcode,
    output logic [ADDR_W-1:0]     vec_addr
);
    logic     pend_q, pend_d;
    brk_evt_t evt_q, evt_d;

    // A break leaves only at an instruction boundary
    assign take_now = brk_en && (hit || pend_q) && instr_last;

    always_comb begin
        if (!brk_en)        pend_d = 1'b0;
        else if (instr_last) pend_d = 1'b0;
        else                pend_d = pend_q || hit;
        evt_d.take = take_now;
        evt_d.mon  = monitor_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            evt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            evt_q  <= evt_d;
        end
    end

    assign brk_take   = evt_q.take;
    assign swi_opcode = evt_q.take ? SWI_OP : '0;
    assign vec_addr   = !evt_q.take ? '0 : (evt_q.mon ? MON_VEC : NORM_VEC);
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brkpt_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NORM_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] MON_VEC  = 16'hFEFC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_OFF_W-1:0]  reg_addr,
    input  logic                  reg_wr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  instr_last,
    input  logic                  monitor_mode,
    input  logic                  cpu_in_wait,
    output logic                  brk_take,
    output logic                  brk_active,
    output logic [REG_DATA_W-1:0] swi_opcode,
    output logic [ADDR_W-1:0]     vec_addr
);
    reg_wr_t           wr;
    logic [ADDR_W-1:0] brk_addr;
    logic              brk_en, addr_eq, hit, take_now;

    assign wr.we   = reg_wr;
    assign wr.off  = reg_addr;
    assign wr.data = reg_wdata;
    assign hit     = addr_eq && brk_en;

    brkpt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .cpu_addr (cpu_addr),
        .brk_addr (brk_addr),
        .addr_eq  (addr_eq)
    );

    brkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .hit         (hit),
        .take_now    (take_now),
        .cpu_in_wait (cpu_in_wait),
        .rdata       (reg_rdata),
        .brk_addr    (brk_addr),
        .brk_en      (brk_en),
        .brk_active  (brk_active)
    );

    brkpt_sequencer #(
        .ADDR_W   (ADDR_W),
        .NORM_VEC (NORM_VEC),
        .MON_VEC  (MON_VEC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .brk_en       (brk_en),
        .hit          (hit),
        .instr_last   (instr_last),
        .monitor_mode (monitor_mode),
        .take_now     (take_now),
        .brk_take     (brk_take),
        .swi_opcode   (swi_opcode),
        .vec_addr     (vec_addr)
    );
endmodule

// File: rtl/brkpt_checker.sv
module brkpt_checker
    import brkpt_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NORM_VEC = 16'hFFFC,
    parameter logic [ADDR_W-1:0] MON_VEC  = 16'hFEFC
) (
    input logic                  clk,
    input logic                  rst,
    input logic [REG_OFF_W-1:0]  reg_addr,
    input logic                  reg_wr,
    input logic                  clr_bit,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic                  instr_last,
    input logic                  monitor_mode,
    input logic                  brk_take,
    input logic                  brk_active,
    input logic [REG_DATA_W-1:0] swi_opcode,
    input logic [ADDR_W-1:0]     vec_addr,
    input logic                  brk_en,
    input logic [ADDR_W-1:0]     brk_addr
);
    assert_disarmed_silent_R3: assert property (@(posedge clk) disable iff (rst)
        $past(!brk_en) |-> !brk_take);

    assert_flag_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_active) |-> $past(brk_en && cpu_addr == brk_addr));

    assert_flag_clear_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(brk_active) |-> $past(reg_wr && int'(reg_addr) == OFF_CTL && !clr_bit));

    assert_boundary_take_R5: assert property (@(posedge clk) disable iff (rst)
        (brk_en && cpu_addr == brk_addr && instr_last) |=> brk_take);

    assert_take_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        brk_take |-> $past(instr_last));

    assert_vector_R7: assert property (@(posedge clk) disable iff (rst)
        brk_take |-> (swi_opcode == SWI_OP
                      && vec_addr == ($past(monitor_mode) ? MON_VEC : NORM_VEC)));

    assert_idle_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        !brk_take |-> (swi_opcode == '0 && vec_addr == '0));
endmodule

bind brkpt_unit brkpt_checker #(
    .ADDR_W   (ADDR_W),
    .NORM_VEC (NORM_VEC),
    .MON_VEC  (MON_VEC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .clr_bit      (reg_wdata[brkpt_pkg::BIT_ACT]),
    .cpu_addr     (cpu_addr),
    .instr_last   (instr_last),
    .monitor_mode (monitor_mode),
    .brk_take     (brk_take),
    .brk_active   (brk_active),
    .swi_opcode   (swi_opcode),
    .vec_addr     (vec_addr),
    .brk_en       (brk_en),
    .brk_addr     (brk_addr)
);

// File: tb/test_brkpt_unit.sv
`timescale 1ns/1ps
module test_brkpt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = '0;
    logic        instr_last = 1'b0;
    logic        monitor_mode = 1'b0;
    logic        cpu_in_wait = 1'b0;
    logic        brk_take, brk_active;
    logic [7:0]  swi_opcode;
    logic [15:0] vec_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    brkpt_unit i_brkpt_unit (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr),
        .instr_last(instr_last), .monitor_mode(monitor_mode),
        .cpu_in_wait(cpu_in_wait), .brk_take(brk_take), .brk_active(brk_active),
        .swi_opcode(swi_opcode), .vec_addr(vec_addr)
    );

    function automatic logic [15:0] exp_vec(input logic take, input logic mon);
        if (!take) return 16'h0000;
        return mon ? 16'hFEFC : 16'hFFFC;
    endfunction

    function automatic logic [7:0] exp_op(input logic take);
        return take ? 8'h83 : 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic cyc(input logic [15:0] a, input logic last, input logic mon);
        cpu_addr = a; instr_last = last; monitor_mode = mon;
        @(negedge clk);
        cpu_addr = '0; instr_last = 1'b0;
    endtask

    task automatic chk_out(input string req, input logic take, input logic mon);
        chk(req, brk_take, take);
        chk(req, vec_addr, exp_vec(take, mon));
        chk(req, swi_opcode, exp_op(take));
    endtask

    task automatic run_random(input int cycles, input logic en, input logic [15:0] brk);
        logic m_pend = 1'b0, m_take = 1'b0, m_mon = 1'b0, m_act = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            logic hit;
            chk("R5/R6 random take", brk_take, m_take);
            chk("R7 random vector", vec_addr, exp_vec(m_take, m_mon));
            chk("R3 random flag", brk_active, m_act);
            cpu_addr     = ($urandom % 4 == 0) ? brk : 16'($urandom);
            instr_last   = ($urandom % 3 == 0);
            monitor_mode = $urandom % 2;
            hit    = en && (cpu_addr == brk);
            m_take = en && (hit || m_pend) && instr_last;
            m_pend = en && !instr_last && (m_pend || hit);
            m_act  = m_act || hit;
            m_mon  = monitor_mode;
            @(negedge clk);
        end
        cpu_addr = '0; instr_last = 1'b0; monitor_mode = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL timeout: actual hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rb;
        void'($urandom(32'h0BAD_5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 status reset", 4'h0, 8'h10);
        rd_chk("R1 flagctl reset", 4'h3, 8'h00);
        rd_chk("R1 addr hi reset", 4'h9, 8'h00);
        rd_chk("R1 addr lo reset", 4'hA, 8'h00);
        rd_chk("R1 ctl reset", 4'hB, 8'h00);
        chk_out("R1 no pulse", 1'b0, 1'b0);

        // R2 address registers and unmapped offsets
        wr(4'h9, 8'h12);
        wr(4'hA, 8'h34);
        rd_chk("R2 addr hi", 4'h9, 8'h12);
        rd_chk("R2 addr lo", 4'hA, 8'h34);
        wr(4'h5, 8'hFF);
        rd_chk("R2 unmapped read", 4'h5, 8'h00);
        rd_chk("R2 hi untouched", 4'h9, 8'h12);
        rd_chk("R2 lo untouched", 4'hA, 8'h34);
        rd_chk("R2 ctl untouched", 4'hB, 8'h00);

        // R9 flag control register
        wr(4'h3, 8'hFF);
        rd_chk("R9 fce set", 4'h3, 8'h80);
        wr(4'h3, 8'h00);
        rd_chk("R9 fce clear", 4'h3, 8'h00);

        // R3 disarmed: no flag, no pulse
        cyc(16'h1234, 1'b1, 1'b0);
        chk_out("R3 disarmed no pulse", 1'b0, 1'b0);
        chk("R3 disarmed no flag", brk_active, 1'b0);

        // Arm, then partial matches on each byte
        wr(4'hB, 8'h80);
        rd_chk("R3 arm readback", 4'hB, 8'h80);
        cyc(16'h1235, 1'b1, 1'b0);
        chk_out("R3 low byte differs", 1'b0, 1'b0);
        cyc(16'h1334, 1'b1, 1'b0);
        chk_out("R3 high byte differs", 1'b0, 1'b0);
        chk("R3 partial no flag", brk_active, 1'b0);

        // R6 deferred break in monitor mode
        cyc(16'h1234, 1'b0, 1'b0);
        chk("R3 flag set", brk_active, 1'b1);
        chk_out("R6 no pulse mid-instr", 1'b0, 1'b0);
        cyc(16'h0000, 1'b0, 1'b1);
        chk_out("R6 still pending", 1'b0, 1'b0);
        cyc(16'h0000, 1'b1, 1'b1);
        chk_out("R6 R7 pulse monitor vector", 1'b1, 1'b1);
        cyc(16'h0000, 1'b0, 1'b0);
        chk_out("R6 single pulse", 1'b0, 1'b0);

        // R4 write-one has no effect, write-zero clears
        wr(4'hB, 8'hC0);
        rd_chk("R4 write one keeps", 4'hB, 8'hC0);
        wr(4'hB, 8'h80);
        rd_chk("R4 write zero clears", 4'hB, 8'h80);

        // R5 immediate break, normal vector
        cyc(16'h1234, 1'b1, 1'b0);
        chk_out("R5 R7 immediate pulse", 1'b1, 1'b0);

        // R4 hit in same cycle as clearing write: set wins
        @(negedge clk);
        reg_addr = 4'hB; reg_wdata = 8'h80; reg_wr = 1'b1; cpu_addr = 16'h1234;
        @(negedge clk);
        reg_wr = 1'b0; cpu_addr = '0;
        rd_chk("R4 set beats clear", 4'hB, 8'hC0);

        // R6 disarm discards the pending break left above
        wr(4'hB, 8'h00);
        wr(4'hB, 8'h80);
        cyc(16'h0000, 1'b1, 1'b0);
        chk_out("R6 pending discarded", 1'b0, 1'b0);

        // R8 wait-break flag
        cpu_in_wait = 1'b1;
        cyc(16'h1234, 1'b1, 1'b0);
        cpu_in_wait = 1'b0;
        chk_out("R8 pulse in wait", 1'b1, 1'b0);
        rd_chk("R8 wait flag set", 4'h0, 8'h12);
        wr(4'h0, 8'hFF);
        rd_chk("R8 write one no effect", 4'h0, 8'h12);
        wr(4'h0, 8'h00);
        rd_chk("R8 write zero clears", 4'h0, 8'h10);

        // Random phases, armed then disarmed
        rb = 16'($urandom) | 16'h0001;
        wr(4'h9, rb[15:8]);
        wr(4'hA, rb[7:0]);
        wr(4'hB, 8'h00);
        wr(4'hB, 8'h80);
        run_random(1500, 1'b1, rb);
        wr(4'hB, 8'h00);
        run_random(300, 1'b0, rb);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule